// File: doc/BRIEF.md
# Nine-Level Phase-Disposition PWM Modulator for a 3:2 Cascaded Bridge Pair

This block turns a signed reference sample into gate commands for two H-bridges connected in series. The first bridge sits on a DC link 1.5 times the voltage of the second. Their outputs add, so the pair can reach nine distinct voltages: 0, ±(V1−V2), ±V2, ±V1 and ±(V1+V2). With V2 taken as 2 units and V1 as 3 units, these are 0, ±1, ±2, ±3 and ±5 units.

A single up/down counter forms a triangle of height H, where H is the period input. Eight carriers are cut from this triangle. Four are stacked above zero and four below, and all of them run in phase. The reference is compared against every carrier. The comparison results are reduced to a signed level index from −4 to +4. That index is then decoded into one switch pattern per bridge. Levels, gates and the triangle all share one register stage, so the eight switch lines and the level code change on the same clock edge.

Top module: `nine_level_spwm`

## Requirements
- R1: While `rst_n` is low, `level_out` is 0, both gate buses hold the zero pattern 4'b0101, and the triangle counter is held at 0 in its rising phase.
- R2: With effective height H (`period_in`, where 0 is treated as 1), the triangle value t rises by one per clock from 0 to H and then falls by one per clock back to 0, for a period of 2H clocks. If H shrinks while t is above it, t is set to H on the next clock and then falls.
- R3: Upper carrier j (j = 1..4) equals (j−1)·H + t, and lower carrier j equals t − j·H. The level index is the number of upper carriers strictly below the reference minus the number of lower carriers strictly above it. `level_out` is a 4-bit two's-complement value in −4..+4.
- R4: Each level index selects a (bridge 1, bridge 2) state pair, with states +1, 0 and −1. The pairs for indices 0, 1, 2, 3 and 4 are (0,0), (+1,−1), (0,+1), (+1,0) and (+1,+1). These give 3·b1 + 2·b2 = 0, 1, 2, 3 and 5.
- R5: Gate bus bit 0 drives switch 1 and bit 3 drives switch 4. A bridge state of +1 drives 4'b1001, −1 drives 4'b0110, and 0 drives 4'b0101.
- R6: Level 0 puts the zero pattern 4'b0101 on both bridges.
- R7: A negative index uses the pair of its magnitude with both states negated, so the output voltage is the exact mirror of the positive one.
- R8: `level_out`, `gate_h1` and `gate_h2` change together, one clock after the reference and period are sampled. They use the triangle value held at that edge.
- R9: A reference above 4·H gives +4 at every triangle position, and a reference below −4·H gives −4. A reference of exactly 4·H gives +3 at the triangle peak, and exactly −4·H gives −3 at the triangle valley.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | REF_W (12) | Signed reference, in triangle count units; full scale is ±4·H |
| period_in | input | PER_W (9) | Triangle height H in clocks (one half carrier period) |
| gate_h1 | output | 4 | Switches 1..4 of the high-voltage bridge (bit 0 = switch 1) |
| gate_h2 | output | 4 | Switches 1..4 of the low-voltage bridge (bit 0 = switch 1) |
| level_out | output | 4 | Signed level index −4..+4 |

## Verification
The bench targets the band edges, where a reference equal to a carrier must not count. An off-by-one comparison would show up as level ±4 at the triangle peak with a reference of exactly 4·H, or as a nonzero level at a zero reference.

It drives references into every band and checks the output voltage of the bridge pair against the level table. A swapped pair in the decode would produce a non-monotonic staircase, for example 2 units where 1 belongs. A mirror error would break the symmetry between positive and negative indices.

Shrinking the period while the triangle is above the new height, and setting the period to zero, expose a counter that overruns or stalls. Such a counter would drift every later level away from the expected sequence.

// File: rtl/nine_level_spwm.sv
module nine_level_spwm #(
  parameter int REF_W = 12,
  parameter int PER_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [PER_W-1:0]        period_in,
  output logic [3:0]              gate_h1,
  output logic [3:0]              gate_h2,
  output logic signed [3:0]       level_out
);

  localparam int CW = ((REF_W > PER_W + 3) ? REF_W : PER_W + 3) + 1;
  localparam logic [3:0] PAT_POS  = 4'b1001;
  localparam logic [3:0] PAT_NEG  = 4'b0110;
  localparam logic [3:0] PAT_ZERO = 4'b0101;

  logic [PER_W-1:0] h, tri_q;
  logic             rising_q;

  assign h = (period_in == '0) ? PER_W'(1) : period_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tri_q    <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      if (tri_q >= h - PER_W'(1)) begin
        tri_q    <= h;
        rising_q <= 1'b0;
      end else begin
        tri_q <= tri_q + PER_W'(1);
      end
    end else begin
      if (tri_q > h) begin
        tri_q <= h;
      end else if (tri_q <= PER_W'(1)) begin
        tri_q    <= '0;
        rising_q <= 1'b1;
      end else begin
        tri_q <= tri_q - PER_W'(1);
      end
    end
  end

  logic signed [CW-1:0] ref_x, tri_x, h_x;
  logic signed [CW-1:0] off [0:4];

  assign ref_x = $signed({{(CW-REF_W){ref_in[REF_W-1]}}, ref_in});
  assign tri_x = $signed({{(CW-PER_W){1'b0}}, tri_q});
  assign h_x   = $signed({{(CW-PER_W){1'b0}}, h});

  always_comb begin
    off[0] = '0;
    for (int k = 1; k < 5; k++) off[k] = off[k-1] + h_x;
  end

  logic [3:0] up_hit, dn_hit;
  for (genvar j = 0; j < 4; j++) begin : g_band
    assign up_hit[j] = (tri_x + off[j]) < ref_x;
    assign dn_hit[j] = (tri_x - off[j+1]) > ref_x;
  end

  logic [2:0] n_up, n_dn;
  logic signed [3:0] lvl_c;
  assign n_up  = 3'($countones(up_hit));
  assign n_dn  = 3'($countones(dn_hit));
  assign lvl_c = $signed({1'b0, n_up}) - $signed({1'b0, n_dn});

  logic [2:0] mag;
  logic signed [1:0] m1, m2, b1, b2;

  always_comb begin
    mag = lvl_c[3] ? 3'(-lvl_c) : 3'(lvl_c);
    case (mag)
      3'd1:    begin m1 = 2'sd1; m2 = -2'sd1; end
      3'd2:    begin m1 = 2'sd0; m2 =  2'sd1; end
      3'd3:    begin m1 = 2'sd1; m2 =  2'sd0; end
      3'd4:    begin m1 = 2'sd1; m2 =  2'sd1; end
      default: begin m1 = 2'sd0; m2 =  2'sd0; end
    endcase
    b1 = lvl_c[3] ? -m1 : m1;
    b2 = lvl_c[3] ? -m2 : m2;
  end

  function automatic logic [3:0] pat(input logic signed [1:0] b);
    if (b > 0)      return PAT_POS;
    else if (b < 0) return PAT_NEG;
    else            return PAT_ZERO;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_out <= '0;
      gate_h1   <= PAT_ZERO;
      gate_h2   <= PAT_ZERO;
    end else begin
      level_out <= lvl_c;
      gate_h1   <= pat(b1);
      gate_h2   <= pat(b2);
    end
  end

  function automatic int pat_volt(input logic [3:0] g);
    if (g == PAT_POS)      return 1;
    else if (g == PAT_NEG) return -1;
    else                   return 0;
  endfunction

  function automatic int lvl_volt(input logic signed [3:0] l);
    int a;
    a = (l < 0) ? -int'(l) : int'(l);
    a = (a == 4) ? 5 : a;
    return (l < 0) ? -a : a;
  endfunction

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (level_out == 4'sd0 && gate_h1 == PAT_ZERO && gate_h2 == PAT_ZERO));

  p_tri_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_q > 0 && tri_q < h) |=>
      (tri_q == $past(tri_q) + PER_W'(1) || tri_q == $past(tri_q) - PER_W'(1)));

  p_level_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out >= -4'sd4 && level_out <= 4'sd4));

  p_pair_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (3 * pat_volt(gate_h1) + 2 * pat_volt(gate_h2) == lvl_volt(level_out)));

  p_legal_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_h1 == PAT_POS || gate_h1 == PAT_NEG || gate_h1 == PAT_ZERO) &&
     (gate_h2 == PAT_POS || gate_h2 == PAT_NEG || gate_h2 == PAT_ZERO)));

  p_zero_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out == 4'sd0) |-> (gate_h1 == PAT_ZERO && gate_h2 == PAT_ZERO));

  p_sat_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_x > off[4]) |=> (level_out == 4'sd4));

  p_sat_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_x < -off[4]) |=> (level_out == -4'sd4));

endmodule

// File: tb/nine_level_spwm_test.sv
module nine_level_spwm_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [11:0] ref_in = '0;
  logic [8:0]        period_in = 9'd8;
  logic [3:0]        gate_h1, gate_h2;
  logic signed [3:0] level_out;

  int checks = 0, errors = 0;
  int m_t = 0;
  bit m_up = 1'b1;
  logic [11:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  nine_level_spwm uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .period_in(period_in),
    .gate_h1(gate_h1), .gate_h2(gate_h2), .level_out(level_out)
  );

  function automatic logic [3:0] pat_of(int b);
    if (b > 0) return 4'b1001;
    if (b < 0) return 4'b0110;
    return 4'b0101;
  endfunction

  function automatic logic [11:0] expect_of(int r, int h, int t);
    int lvl, target, vt[5], p1, p2;
    vt = '{0, 1, 2, 3, 5};
    lvl = 0;
    for (int k = 1; k <= 4; k++) begin
      if ((k - 1) * h + t < r) lvl++;
      if (t - k * h > r) lvl--;
    end
    target = (lvl < 0) ? -vt[-lvl] : vt[lvl];
    p1 = 0; p2 = 0;
    for (int a = -1; a <= 1; a++)
      for (int b = -1; b <= 1; b++)
        if (3 * a + 2 * b == target) begin p1 = a; p2 = b; end
    return {4'(lvl), pat_of(p1), pat_of(p2)};
  endfunction

  task automatic step(int r, int per, string tag);
    int h;
    h = (per == 0) ? 1 : per;
    ref_in = 12'(r);
    period_in = 9'(per);
    exp_q.push_back(expect_of(r, h, m_t));
    tag_q.push_back(tag);
    if (m_up) begin
      if (m_t >= h - 1) begin m_t = h; m_up = 1'b0; end
      else m_t++;
    end else begin
      if (m_t > h) m_t = h;
      else if (m_t <= 1) begin m_t = 0; m_up = 1'b1; end
      else m_t--;
    end
    @(negedge clk);
  endtask

  initial begin : monitor
    logic [11:0] e, a;
    string tg;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        a = {level_out, gate_h1, gate_h2};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: level/g1/g2 actual %0d/%b/%b expected %0d/%b/%b",
                   tg, $signed(a[11:8]), a[7:4], a[3:0], $signed(e[11:8]), e[7:4], e[3:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    ref_in = 12'sd20;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (level_out !== 4'sd0 || gate_h1 !== 4'b0101 || gate_h2 !== 4'b0101) begin
      errors++;
      $display("FAIL R1: actual %0d/%b/%b expected 0/0101/0101", level_out, gate_h1, gate_h2);
    end
    rst_n = 1'b1;
    // R6 zero reference over two full carrier periods
    for (int i = 0; i < 32; i++) step(0, 8, "R6");
    // R2 small reference traces the triangle shape
    for (int i = 0; i < 32; i++) step(4, 8, "R2");
    for (int i = 0; i < 32; i++) step(-5, 8, "R2/R7");
    // R3 R4 R5 R7 each band, both signs
    for (int v = -30; v <= 30; v += 6)
      for (int i = 0; i < 17; i++) step(v, 8, "R3/R4/R5/R7");
    // R8 reference changing every clock
    for (int i = 0; i < 80; i++) step(((i * 13) % 71) - 35, 8, "R8");
    // R9 saturation and exact edges
    for (int i = 0; i < 17; i++) step(33, 8, "R9");
    for (int i = 0; i < 17; i++) step(-33, 8, "R9");
    for (int i = 0; i < 17; i++) step(32, 8, "R9");
    for (int i = 0; i < 17; i++) step(-32, 8, "R9");
    // R2 period shrink while above new height, zero period, growth
    for (int i = 0; i < 6; i++) step(7, 8, "R2");
    for (int i = 0; i < 20; i++) step(7, 3, "R2");
    for (int i = 0; i < 10; i++) step(2, 0, "R2");
    for (int i = 0; i < 90; i++) step((i % 2 == 0) ? 50 : -47, 20, "R2/R3");
    for (int i = 0; i < 60; i++) step(i - 30, 5, "R3/R4");
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (level_out !== 4'sd0 || gate_h1 !== 4'b0101 || gate_h2 !== 4'b0101) begin
      errors++;
      $display("FAIL R1: actual %0d/%b/%b expected 0/0101/0101", level_out, gate_h1, gate_h2);
    end
    wait (exp_q.size() == 0);
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule